// File: doc/BRIEF.md
# Serial Control Word Command Decoder

This block is the slave end of a three-wire serial control bus on a radio-interface chip. A controller clocks 24-bit control words into the block one bit per rising edge of the bus clock and then pulses one of two latch strobes. One strobe hands the word to the radio-interface decoder here. The other passes the word untouched to the synthesiser section through a valid/ready output.

A radio-interface word is split into three bytes, called byte A (first sent), byte B and byte C. The top two bits of byte B select one of four command classes. The decoder keeps a sleep/awake state and a small file of set-up registers. It raises a one-cycle restart request, flags test commands and, after a Normal command only, turns the data line around for eight cycles. During those cycles it returns a reply byte taken from a parallel valid/ready input.

The block also watches the spacing between latch pulses and reports a settling delay after a Sleep command.

The reply input has no waiting. `reply_ready` is high only during the latch cycle of a Normal command, and the byte is taken in that cycle if `reply_valid` is high; otherwise zeros are sent. The synthesiser output holds `syn_valid` and `syn_word` until `syn_ready` is seen. A newer synthesiser latch replaces a word that has not yet been taken.

Top module: `scw_decoder`

## Requirements
- R1: Data on `sdi` is sampled on each rising clock edge that has no latch high. A word is the last 24 bits sampled before the latch, first bit most significant. Byte A is word[23:16], byte B is word[15:8] and byte C is word[7:0].
- R2: Byte B bits 7:6 give the command class: 00 Sleep, 01 Normal, 10 Set-up, 11 Test.
- R3: A radio-interface Sleep command sets `sleeping` from the next cycle on. Only a Normal command clears it. Set-up, Test and synthesiser words leave it unchanged.
- R4: A Set-up command writes byte A into configuration register number byte C[3:2], which appears at `cfg_regs[8*n+7:8*n]`. No other command changes any register, sleeping or not.
- R5: `restart_req` is high for exactly the one cycle after the latch edge of a Set-up command whose byte C[1:0] is 11. It stays low for any other value of those bits and for every other class.
- R6: A Test command pulses `test_hit` for one cycle and has no other effect.
- R7: During the latch cycle of a Normal command, `reply_ready` is high. The reply byte is `reply_data` if `reply_valid` is high, else 00. It is driven on `sdo` most significant bit first, one bit per clock, with `sdo_oe` high for the 8 cycles after the latch edge. `sdo_oe` is low at all other times.
- R8: A synthiser latch loads the 24-bit word into `syn_word` and sets `syn_valid`. Both hold until a cycle with `syn_ready` high.
- R9: `timing_err` becomes set, and stays set until reset, when two latch edges (of either kind) are fewer than 30 clocks apart, or fewer than 36 while `ext_cmd` is high. The first latch after reset never sets it.
- R10: `settled` is low after reset and after a Sleep latch edge. It rises exactly 8 clocks later.
- R11: After reset the block is awake, with all flags low, `sdo_oe` low, `syn_valid` low and every configuration register zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdi | input | 1 | Serial data from the controller |
| latch_ri | input | 1 | Ends a radio-interface word |
| latch_syn | input | 1 | Ends a synthesiser word |
| ext_cmd | input | 1 | Selects the longer minimum latch spacing |
| reply_data | input | 8 | Reply byte source |
| reply_valid | input | 1 | Reply byte is present |
| reply_ready | output | 1 | Reply byte taken this cycle |
| sdo | output | 1 | Serial reply data |
| sdo_oe | output | 1 | Drive enable for the shared data line |
| syn_word | output | 24 | Synthesiser word |
| syn_valid | output | 1 | Synthesiser word pending |
| syn_ready | input | 1 | Synthesiser word accepted |
| sleeping | output | 1 | Sleep state |
| restart_req | output | 1 | One-cycle logic restart request |
| test_hit | output | 1 | One-cycle test command flag |
| timing_err | output | 1 | Sticky latch spacing violation |
| settled | output | 1 | Control logic settled |
| cfg_regs | output | 32 | Configuration registers, register n at bits 8n+7:8n |

## Verification
The hardest condition to reach is the exact edge of the spacing rule: a separation of 29 clocks must flag and one of 30 must not, and 35 against 36 must behave the same way with the extended mode on. The bench's word task takes a count of idle clocks before the first data bit, which places each latch on a chosen clock. Those pairs are run on a fresh reset each time, because the flag is sticky. The settling flag after Sleep is also sampled on the cycle before it and the cycle it rises.

// File: rtl/scw_pkg.sv
package scw_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_BYTES = 3;
  localparam int WORD_W = BYTE_W * WORD_BYTES;

  typedef enum logic [1:0] {
    CMD_SLEEP  = 2'b00,
    CMD_NORMAL = 2'b01,
    CMD_SETUP  = 2'b10,
    CMD_TEST   = 2'b11
  } cmd_e;
endpackage

// File: rtl/scw_shift.sv
module scw_shift #(
  parameter int WORD_W      = 24,
  parameter int GAP_W       = 6,
  parameter int MIN_GAP     = 30,
  parameter int MIN_GAP_EXT = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              latch_any,
  input  logic              ext_cmd,
  output logic [WORD_W-1:0] word,
  output logic              timing_err
);
  localparam logic [GAP_W-1:0] LIM_STD = GAP_W'(MIN_GAP - 1);
  localparam logic [GAP_W-1:0] LIM_EXT = GAP_W'(MIN_GAP_EXT - 1);

  logic [WORD_W-1:0] sreg;
  logic [GAP_W-1:0]  gap;
  logic [GAP_W-1:0]  lim;

  assign lim  = ext_cmd ? LIM_EXT : LIM_STD;
  assign word = sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg       <= '0;
      gap        <= '1;
      timing_err <= 1'b0;
    end else if (latch_any) begin
      gap <= '0;
      if (gap < lim) timing_err <= 1'b1;
    end else begin
      sreg <= {sreg[WORD_W-2:0], sdi};
      if (gap != '1) gap <= gap + 1'b1;
    end
  end
endmodule

// File: rtl/scw_decode.sv
module scw_decode
  import scw_pkg::*;
#(
  parameter int NREG     = 4,
  parameter int ADDR_LSB = 2,
  localparam int AW      = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   latch_ri,
  input  logic [WORD_W-1:0]      word,
  output logic                   is_normal,
  output logic                   is_sleep,
  output logic                   sleeping,
  output logic                   restart_req,
  output logic                   test_hit,
  output logic [NREG*BYTE_W-1:0] cfg_flat
);
  logic [BYTE_W-1:0] byte_a, byte_b, byte_c;
  cmd_e              cls;
  logic [AW-1:0]     addr;
  logic              wr_en;

  assign byte_a = word[3*BYTE_W-1:2*BYTE_W];
  assign byte_b = word[2*BYTE_W-1:BYTE_W];
  assign byte_c = word[BYTE_W-1:0];
  assign cls    = cmd_e'(byte_b[7:6]);
  assign addr   = byte_c[ADDR_LSB +: AW];

  assign is_normal = latch_ri && (cls == CMD_NORMAL);
  assign is_sleep  = latch_ri && (cls == CMD_SLEEP);
  assign wr_en     = latch_ri && (cls == CMD_SETUP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleeping    <= 1'b0;
      restart_req <= 1'b0;
      test_hit    <= 1'b0;
    end else begin
      if (is_sleep) sleeping <= 1'b1;
      else if (is_normal) sleeping <= 1'b0;
      restart_req <= wr_en && (byte_c[1:0] == 2'b11);
      test_hit    <= latch_ri && (cls == CMD_TEST);
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [BYTE_W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else if (wr_en && (addr == AW'(g))) r <= byte_a;
    end
    assign cfg_flat[g*BYTE_W +: BYTE_W] = r;
  end
endmodule

// File: rtl/scw_reply.sv
module scw_reply #(
  parameter int BYTE_W = 8,
  localparam int CW    = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_ri,
  input  logic              load,
  input  logic [BYTE_W-1:0] data_in,
  input  logic              data_valid,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [BYTE_W-1:0] sh;
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (latch_ri) begin
      if (load) begin
        sh  <= data_valid ? data_in : '0;
        cnt <= CW'(BYTE_W);
      end else begin
        cnt <= '0;
      end
    end else if (cnt != '0) begin
      sh  <= {sh[BYTE_W-2:0], 1'b0};
      cnt <= cnt - 1'b1;
    end
  end

  assign sdo    = sh[BYTE_W-1];
  assign sdo_oe = (cnt != '0);
endmodule

// File: rtl/scw_decoder.sv
module scw_decoder
  import scw_pkg::*;
#(
  parameter int NREG        = 4,
  parameter int GAP_W       = 6,
  parameter int MIN_GAP     = 30,
  parameter int MIN_GAP_EXT = 36,
  parameter int SETTLE_CYC  = 8,
  localparam int SW         = $clog2(SETTLE_CYC + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sdi,
  input  logic                   latch_ri,
  input  logic                   latch_syn,
  input  logic                   ext_cmd,
  input  logic [BYTE_W-1:0]      reply_data,
  input  logic                   reply_valid,
  output logic                   reply_ready,
  output logic                   sdo,
  output logic                   sdo_oe,
  output logic [WORD_W-1:0]      syn_word,
  output logic                   syn_valid,
  input  logic                   syn_ready,
  output logic                   sleeping,
  output logic                   restart_req,
  output logic                   test_hit,
  output logic                   timing_err,
  output logic                   settled,
  output logic [NREG*BYTE_W-1:0] cfg_regs
);
  logic [WORD_W-1:0] word;
  logic              is_normal, is_sleep;
  logic [SW-1:0]     settle_cnt;

  scw_shift #(
    .WORD_W(WORD_W), .GAP_W(GAP_W),
    .MIN_GAP(MIN_GAP), .MIN_GAP_EXT(MIN_GAP_EXT)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .sdi(sdi),
    .latch_any(latch_ri || latch_syn), .ext_cmd(ext_cmd),
    .word(word), .timing_err(timing_err)
  );

  scw_decode #(.NREG(NREG)) u_dec (
    .clk(clk), .rst_n(rst_n), .latch_ri(latch_ri), .word(word),
    .is_normal(is_normal), .is_sleep(is_sleep), .sleeping(sleeping),
    .restart_req(restart_req), .test_hit(test_hit), .cfg_flat(cfg_regs)
  );

  scw_reply #(.BYTE_W(BYTE_W)) u_reply (
    .clk(clk), .rst_n(rst_n), .latch_ri(latch_ri), .load(is_normal),
    .data_in(reply_data), .data_valid(reply_valid),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  assign reply_ready = is_normal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syn_word  <= '0;
      syn_valid <= 1'b0;
    end else if (latch_syn) begin
      syn_word  <= word;
      syn_valid <= 1'b1;
    end else if (syn_ready) begin
      syn_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settle_cnt <= '0;
    else if (is_sleep) settle_cnt <= '0;
    else if (settle_cnt != SW'(SETTLE_CYC)) settle_cnt <= settle_cnt + 1'b1;
  end

  assign settled = (settle_cnt == SW'(SETTLE_CYC));
endmodule

// File: rtl/scw_decoder_chk.sv
module scw_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        latch_ri,
  input logic        latch_syn,
  input logic        syn_ready,
  input logic        syn_valid,
  input logic [23:0] syn_word,
  input logic        reply_ready,
  input logic        sdo_oe,
  input logic        sleeping,
  input logic        restart_req,
  input logic        test_hit,
  input logic        timing_err,
  input logic        settled
);
  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !restart_req); // R5
  AST_TEST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    test_hit |=> !test_hit); // R6
  AST_OE_AFTER_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(reply_ready)); // R7
  AST_WAKE_BY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleeping) |-> $past(reply_ready)); // R3
  AST_SYN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_valid && !syn_ready && !latch_syn) |=> (syn_valid && $stable(syn_word))); // R8
  AST_TIMING_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err |=> timing_err); // R9
  AST_SETTLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(settled) |-> $past(latch_ri)); // R10
endmodule

bind scw_decoder scw_decoder_chk u_chk (.*);

// File: tb/scw_decoder_test.sv
module scw_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdi = 1'b0, latch_ri = 1'b0, latch_syn = 1'b0, ext_cmd = 1'b0;
  logic [7:0]  reply_data = '0;
  logic        reply_valid = 1'b0, syn_ready = 1'b0;
  logic        reply_ready, sdo, sdo_oe, syn_valid, sleeping, restart_req;
  logic        test_hit, timing_err, settled;
  logic [23:0] syn_word;
  logic [31:0] cfg_regs;
  int checks = 0, errors = 0;
  logic rdy_seen;
  bit done = 0;

  always #4 clk = ~clk;

  scw_decoder uut (.*);

  // word[36:13], reply[12:5], reply_valid[4], sleeping[3], restart[2], test[1], normal[0]
  localparam logic [36:0] VEC [9] = '{
    {24'hA58004, 8'h00, 5'b10000},
    {24'h3C800B, 8'h00, 5'b10100},
    {24'h280000, 8'h00, 5'b11000},
    {24'h77800C, 8'h00, 5'b11000},
    {24'h28C003, 8'h00, 5'b11010},
    {24'h284000, 8'hC3, 5'b10001},
    {24'h284000, 8'h5A, 5'b10001},
    {24'h118001, 8'h00, 5'b10000},
    {24'h284000, 8'h99, 5'b00001}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] w, input bit syn, input int idle);
    repeat (idle) @(negedge clk);
    for (int i = 23; i >= 0; i--) begin
      sdi = w[i];
      @(negedge clk);
    end
    if (syn) latch_syn = 1'b1; else latch_ri = 1'b1;
    #1 rdy_seen = reply_ready;
    @(negedge clk);
    latch_ri = 1'b0;
    latch_syn = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R11 reset state
    chk(!sleeping && !restart_req && !test_hit && !timing_err, "R11 flags", {sleeping, restart_req, test_hit, timing_err}, 0);
    chk(!sdo_oe && !syn_valid && cfg_regs == 0, "R11 outputs", {sdo_oe, syn_valid, cfg_regs[29:0]}, 0);
    chk(!settled, "R10 low after reset", settled, 0);
    rst_n = 1'b1;
    reply_valid = 1'b1;
    syn_ready = 1'b1;

    foreach (VEC[k]) begin
      logic [23:0] w;
      logic [7:0] exp_rep;
      bit nrm, slp_cmd;
      w = VEC[k][36:13];
      nrm = VEC[k][0];
      slp_cmd = (w[15:14] == 2'b00);
      exp_rep = VEC[k][4] ? VEC[k][12:5] : 8'h00;
      reply_data = VEC[k][12:5];
      reply_valid = VEC[k][4];
      send(w, 1'b0, 0);
      chk(rdy_seen == nrm, "R7 reply_ready", rdy_seen, nrm);
      chk(sleeping == VEC[k][3], "R3 sleeping", sleeping, VEC[k][3]);
      chk(restart_req == VEC[k][2], "R5 restart", restart_req, VEC[k][2]);
      chk(test_hit == VEC[k][1], "R6 test", test_hit, VEC[k][1]);
      for (int b = 7; b >= 0; b--) begin
        chk(sdo_oe == nrm, "R7 oe", sdo_oe, nrm);
        if (nrm) chk(sdo == exp_rep[b], "R7 reply bit", sdo, exp_rep[b]);
        if (slp_cmd && b == 0) chk(!settled, "R10 not yet settled", settled, 0);
        if (b == 6) chk(!restart_req && !test_hit, "R5 R6 one cycle", {restart_req, test_hit}, 0);
        @(negedge clk);
      end
      chk(!sdo_oe, "R7 oe released", sdo_oe, 0);
      if (slp_cmd) chk(settled, "R10 settled after 8", settled, 1);
    end
    // R1 R4 byte order and register file
    chk(cfg_regs == 32'h773CA511, "R4 cfg regs", cfg_regs, 32'h773CA511);
    chk(!timing_err, "R9 no error at normal spacing", timing_err, 0);

    // R8 synthesiser handoff with back-pressure
    syn_ready = 1'b0;
    send(24'h00C0DE, 1'b1, 6);
    chk(syn_valid && syn_word == 24'h00C0DE, "R8 syn load", syn_word, 24'h00C0DE);
    repeat (3) @(negedge clk);
    chk(syn_valid && syn_word == 24'h00C0DE, "R8 syn hold", {syn_valid, syn_word}, {1'b1, 24'h00C0DE});
    syn_ready = 1'b1;
    @(negedge clk);
    chk(!syn_valid, "R8 syn accepted", syn_valid, 0);
    chk(!sleeping && cfg_regs == 32'h773CA511 && !sdo_oe, "R3 R4 syn word ignored", cfg_regs, 32'h773CA511);

    // R2 class from byte B: Set-up with C[1:0]=01 no restart, register 0 write
    send(24'h6E8001, 1'b0, 6);
    chk(!restart_req && cfg_regs[7:0] == 8'h6E, "R2 R5 setup no restart", {restart_req, cfg_regs[7:0]}, 9'h06E);

    // R9 spacing boundary, standard
    do_reset();
    send(24'h000000, 1'b1, 0);
    send(24'h000000, 1'b1, 5);
    chk(!timing_err, "R9 spacing 30 ok", timing_err, 0);
    send(24'h000000, 1'b1, 4);
    chk(timing_err, "R9 spacing 29 flagged", timing_err, 1);
    repeat (40) @(negedge clk);
    chk(timing_err, "R9 sticky", timing_err, 1);

    // R9 extended spacing boundary
    do_reset();
    ext_cmd = 1'b1;
    send(24'h000000, 1'b1, 0);
    chk(!timing_err, "R9 first latch exempt", timing_err, 0);
    send(24'h000000, 1'b1, 11);
    chk(!timing_err, "R9 ext spacing 36 ok", timing_err, 0);
    send(24'h000000, 1'b1, 10);
    chk(timing_err, "R9 ext spacing 35 flagged", timing_err, 1);
    ext_cmd = 1'b0;

    // R11 reset clears state again, R10 settles after reset
    do_reset();
    chk(cfg_regs == 0 && !timing_err, "R11 reset clears", cfg_regs, 0);
    repeat (8) @(negedge clk);
    chk(settled, "R10 settled after reset", settled, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule